// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block moves data between two parallel buses, called A and B, in both directions. Each direction has its own storage register, loaded from the bus it reads by the rising edge of a capture clock that belongs to that direction. A select input for each direction chooses what goes out: the live word on the opposite bus, or the word held in that direction's register. Each direction also has an output enable. The A-to-B enable is active high and the B-to-A enable is active low. A capture edge always loads its register, whatever the selects and enables are set to.

The data path is cut into lanes, by default two lanes of eight bits. Each lane has its own clocks, selects and enables, so the block can serve as one wide transceiver or as several narrow ones that run independently. The buses are modelled as separate input, output and output-enable vectors, not as tri-state pins.

A lane whose two directions are both enabled and both in live mode would feed each bus back onto the other. For that case a hold register, clocked by the system clock, keeps the last word that an outside source put on either bus. Both sides then drive the held word, so the model contains no combinational loop.

Top module: `regbus_xcvr`

## Requirements
- R1: On each rising edge of `clk_ab[l]`, lane l's A-to-B register loads lane l of `a_in`. An asynchronous low on `rst_n` clears every register in the block to zero.
- R2: On each rising edge of `clk_ba[l]`, lane l's B-to-A register loads lane l of `b_in`.
- R3: A capture edge loads its register whatever the levels of the select and output-enable inputs, including when that direction's outputs are disabled.
- R4: Outside hold mode, lane l of `b_out` equals lane l of `a_in` when `sel_ab[l]`=0, and equals the lane's A-to-B register when `sel_ab[l]`=1.
- R5: Outside hold mode, lane l of `a_out` equals lane l of `b_in` when `sel_ba[l]`=0, and equals the lane's B-to-A register when `sel_ba[l]`=1.
- R6: Every bit of lane l of `b_oe` is 1 when `oe_ab[l]`=1 and 0 otherwise. Every bit of lane l of `a_oe` is 1 when `oe_ba_n[l]`=0 and 0 otherwise. While a direction is disabled, its output data in that lane is zero.
- R7: The lanes are independent. The clocks, selects and enables of one lane never change another lane's registers or outputs.
- R8: A lane is in hold mode when `sel_ab`=0, `sel_ba`=0, `oe_ab`=1 and `oe_ba_n`=0 in that lane. In hold mode the lane's `a_out` and `b_out` both carry the lane's hold word.
- R9: On each rising edge of `clk`, a lane's hold word loads lane l of `a_in` if `a_ext[l]`=1. Otherwise it loads lane l of `b_in` if `b_ext[l]`=1. Otherwise it keeps its value.
- R10: Both registers of a lane load correctly when their capture clocks rise at the same instant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the hold words |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_ab | input | LANES | A-to-B capture clock, one per lane |
| clk_ba | input | LANES | B-to-A capture clock, one per lane |
| sel_ab | input | LANES | B-side source per lane: 0 live A, 1 stored |
| sel_ba | input | LANES | A-side source per lane: 0 live B, 1 stored |
| oe_ab | input | LANES | B-side output enable, active high |
| oe_ba_n | input | LANES | A-side output enable, active low |
| a_ext | input | LANES | An outside source is driving bus A in this lane |
| b_ext | input | LANES | An outside source is driving bus B in this lane |
| a_in | input | LANES*LANE_W | Value seen on bus A |
| b_in | input | LANES*LANE_W | Value seen on bus B |
| a_out | output | LANES*LANE_W | Data this block drives onto bus A |
| a_oe | output | LANES*LANE_W | Per-bit drive enable for bus A |
| b_out | output | LANES*LANE_W | Data this block drives onto bus B |
| b_oe | output | LANES*LANE_W | Per-bit drive enable for bus B |

## Verification
The assertions check on every system-clock cycle the lane behaviour that depends only on present state. They cover live pass-through in both directions, the polarity of the enables, zero data on a disabled direction, and the hold mode: both sides equal, the word unchanged while no outside source drives, and the word taken from an outside driver. Register capture is timed by the lane clocks, which run apart from the system clock, so only the bench scenarios can show it. These scenarios cover stored transfer, capture while the outputs are disabled, clocks that rise together, and lanes loaded separately with mixed modes.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

   typedef enum logic [1:0] {
      SRC_OFF    = 2'd0,
      SRC_LIVE   = 2'd1,
      SRC_STORED = 2'd2,
      SRC_HOLD   = 2'd3
   } src_e;

   function automatic src_e pick_src(input logic enabled,
                                     input logic stored,
                                     input logic hold_mode);
      if (!enabled)      return SRC_OFF;
      else if (hold_mode) return SRC_HOLD;
      else if (stored)   return SRC_STORED;
      else               return SRC_LIVE;
   endfunction

endpackage

// File: rtl/regbus_capture.sv
module regbus_capture #(
   parameter int W = 8
) (
   input  logic         cap_clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge cap_clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end
endmodule

// File: rtl/regbus_hold.sv
module regbus_hold #(
   parameter int W       = 8,
   parameter bit HOLD_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         a_drv,
   input  logic         b_drv,
   input  logic [W-1:0] a_val,
   input  logic [W-1:0] b_val,
   output logic [W-1:0] q
);
   generate
      if (HOLD_EN) begin : g_keep
         logic [W-1:0] word_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     word_q <= '0;
            else if (a_drv) word_q <= a_val;
            else if (b_drv) word_q <= b_val;
         end
         assign q = word_q;
      end else begin : g_none
         logic unused_in;
         assign unused_in = ^{clk, rst_n, a_drv, b_drv, a_val, b_val};
         assign q = '0;
      end
   endgenerate
endmodule

// File: rtl/regbus_lane.sv
module regbus_lane
   import regbus_pkg::*;
#(
   parameter int W       = 8,
   parameter bit HOLD_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clk_ab,
   input  logic         clk_ba,
   input  logic         sel_ab,
   input  logic         sel_ba,
   input  logic         oe_ab,
   input  logic         oe_ba_n,
   input  logic         a_ext,
   input  logic         b_ext,
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b_in,
   output logic [W-1:0] a_out,
   output logic [W-1:0] a_oe,
   output logic [W-1:0] b_out,
   output logic [W-1:0] b_oe
);
   logic [W-1:0] store_ab, store_ba, hold_w;
   logic         en_a, en_b, hold_mode;
   src_e         src_b, src_a;

   regbus_capture #(.W(W)) u_cap_ab (
      .cap_clk(clk_ab), .rst_n(rst_n), .d(a_in), .q(store_ab));

   regbus_capture #(.W(W)) u_cap_ba (
      .cap_clk(clk_ba), .rst_n(rst_n), .d(b_in), .q(store_ba));

   regbus_hold #(.W(W), .HOLD_EN(HOLD_EN)) u_hold (
      .clk(clk), .rst_n(rst_n), .a_drv(a_ext), .b_drv(b_ext),
      .a_val(a_in), .b_val(b_in), .q(hold_w));

   assign en_b      = oe_ab;
   assign en_a      = ~oe_ba_n;
   assign hold_mode = en_a & en_b & ~sel_ab & ~sel_ba;
   assign src_b     = pick_src(en_b, sel_ab, hold_mode);
   assign src_a     = pick_src(en_a, sel_ba, hold_mode);

   always_comb begin
      unique case (src_b)
         SRC_LIVE:   b_out = a_in;
         SRC_STORED: b_out = store_ab;
         SRC_HOLD:   b_out = hold_w;
         default:    b_out = '0;
      endcase
      unique case (src_a)
         SRC_LIVE:   a_out = b_in;
         SRC_STORED: a_out = store_ba;
         SRC_HOLD:   a_out = hold_w;
         default:    a_out = '0;
      endcase
   end

   assign b_oe = {W{en_b}};
   assign a_oe = {W{en_a}};
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
   parameter int LANE_W  = 8,
   parameter int LANES   = 2,
   parameter bit HOLD_EN = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LANES-1:0]        clk_ab,
   input  logic [LANES-1:0]        clk_ba,
   input  logic [LANES-1:0]        sel_ab,
   input  logic [LANES-1:0]        sel_ba,
   input  logic [LANES-1:0]        oe_ab,
   input  logic [LANES-1:0]        oe_ba_n,
   input  logic [LANES-1:0]        a_ext,
   input  logic [LANES-1:0]        b_ext,
   input  logic [LANES*LANE_W-1:0] a_in,
   input  logic [LANES*LANE_W-1:0] b_in,
   output logic [LANES*LANE_W-1:0] a_out,
   output logic [LANES*LANE_W-1:0] a_oe,
   output logic [LANES*LANE_W-1:0] b_out,
   output logic [LANES*LANE_W-1:0] b_oe
);
   localparam int BUS_W = LANES * LANE_W;

   generate
      if (LANE_W < 1) begin : g_bad_width
         $error("regbus_xcvr: LANE_W must be at least 1");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("regbus_xcvr: LANES must be at least 1");
      end
      if (BUS_W > 4096) begin : g_bad_bus
         $error("regbus_xcvr: bus wider than 4096 bits");
      end
   endgenerate

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         regbus_lane #(.W(LANE_W), .HOLD_EN(HOLD_EN)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .clk_ab (clk_ab[l]),
            .clk_ba (clk_ba[l]),
            .sel_ab (sel_ab[l]),
            .sel_ba (sel_ba[l]),
            .oe_ab  (oe_ab[l]),
            .oe_ba_n(oe_ba_n[l]),
            .a_ext  (a_ext[l]),
            .b_ext  (b_ext[l]),
            .a_in   (a_in [l*LANE_W +: LANE_W]),
            .b_in   (b_in [l*LANE_W +: LANE_W]),
            .a_out  (a_out[l*LANE_W +: LANE_W]),
            .a_oe   (a_oe [l*LANE_W +: LANE_W]),
            .b_out  (b_out[l*LANE_W +: LANE_W]),
            .b_oe   (b_oe [l*LANE_W +: LANE_W]));
      end
   endgenerate
endmodule

// File: rtl/regbus_xcvr_checker.sv
module regbus_xcvr_checker #(
   parameter int LANE_W  = 8,
   parameter int LANES   = 2,
   parameter bit HOLD_EN = 1'b1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [LANES-1:0]        sel_ab,
   input logic [LANES-1:0]        sel_ba,
   input logic [LANES-1:0]        oe_ab,
   input logic [LANES-1:0]        oe_ba_n,
   input logic [LANES-1:0]        a_ext,
   input logic [LANES-1:0]        b_ext,
   input logic [LANES*LANE_W-1:0] a_in,
   input logic [LANES*LANE_W-1:0] b_in,
   input logic [LANES*LANE_W-1:0] a_out,
   input logic [LANES*LANE_W-1:0] a_oe,
   input logic [LANES*LANE_W-1:0] b_out,
   input logic [LANES*LANE_W-1:0] b_oe
);
   generate
      for (genvar l = 0; l < LANES; l++) begin : g_chk
         logic         hm;
         logic [LANE_W-1:0] ai, bi, ao, bo, ae, be;
         assign hm = oe_ab[l] & ~oe_ba_n[l] & ~sel_ab[l] & ~sel_ba[l];
         assign ai = a_in [l*LANE_W +: LANE_W];
         assign bi = b_in [l*LANE_W +: LANE_W];
         assign ao = a_out[l*LANE_W +: LANE_W];
         assign bo = b_out[l*LANE_W +: LANE_W];
         assign ae = a_oe [l*LANE_W +: LANE_W];
         assign be = b_oe [l*LANE_W +: LANE_W];

         assert_live_ab_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (oe_ab[l] && !sel_ab[l] && !hm) |-> (bo == ai));

         assert_live_ba_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!oe_ba_n[l] && !sel_ba[l] && !hm) |-> (ao == bi));

         assert_off_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!oe_ab[l] |-> (be == '0 && bo == '0)) and
            (oe_ba_n[l] |-> (ae == '0 && ao == '0)));

         assert_hold_same_R8: assert property (@(posedge clk) disable iff (!rst_n)
            hm |-> (ao == bo));

         if (HOLD_EN) begin : g_hold_chk
            assert_hold_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
               (hm && $past(hm) && !$past(a_ext[l]) && !$past(b_ext[l])) |-> $stable(bo));

            assert_hold_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
               (hm && $past(a_ext[l])) |-> (bo == $past(ai)));
         end
      end
   endgenerate
endmodule

bind regbus_xcvr regbus_xcvr_checker #(
   .LANE_W(LANE_W), .LANES(LANES), .HOLD_EN(HOLD_EN)
) u_checker (
   .clk(clk), .rst_n(rst_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
   .oe_ab(oe_ab), .oe_ba_n(oe_ba_n), .a_ext(a_ext), .b_ext(b_ext),
   .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe),
   .b_out(b_out), .b_oe(b_oe));

// File: tb/regbus_xcvr_bench.sv
module regbus_xcvr_bench;
   localparam int LW = 8;
   localparam int LN = 2;
   localparam int BW = LW * LN;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [LN-1:0] clk_ab, clk_ba, sel_ab, sel_ba, oe_ab, oe_ba_n, a_ext, b_ext;
   logic [BW-1:0] a_in, b_in, a_out, a_oe, b_out, b_oe;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   regbus_xcvr #(.LANE_W(LW), .LANES(LN)) u_regbus_xcvr (
      .clk(clk), .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba),
      .sel_ab(sel_ab), .sel_ba(sel_ba), .oe_ab(oe_ab), .oe_ba_n(oe_ba_n),
      .a_ext(a_ext), .b_ext(b_ext), .a_in(a_in), .b_in(b_in),
      .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe));

   task automatic chk(input string req, input logic [BW-1:0] got, input logic [BW-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic pulse(input logic [LN-1:0] m_ab, input logic [LN-1:0] m_ba);
      #1 clk_ab = m_ab; clk_ba = m_ba;
      #1 clk_ab = '0;   clk_ba = '0;
      #1;
   endtask

   task automatic t_reset;
      sel_ab = '1; sel_ba = '1; oe_ab = '1; oe_ba_n = '0; #1;
      chk("R1 reset A-to-B store", b_out, 16'h0000);
      chk("R1 reset B-to-A store", a_out, 16'h0000);
      chk("R6 b_oe on", b_oe, 16'hFFFF);
      chk("R6 a_oe on", a_oe, 16'hFFFF);
      oe_ab = '0; oe_ba_n = '1; #1;
      chk("R6 b_oe off", b_oe, 16'h0000);
      chk("R6 a_oe off", a_oe, 16'h0000);
      chk("R6 b data zero when off", b_out, 16'h0000);
   endtask

   task automatic t_live;
      sel_ab = '0; sel_ba = '0; oe_ab = '1; oe_ba_n = '1;
      a_in = 16'h3C91; b_in = 16'h7E02; #1;
      chk("R4 live A to B", b_out, 16'h3C91);
      a_in = 16'hF00D; #1;
      chk("R4 live A to B follows", b_out, 16'hF00D);
      oe_ab = '0; oe_ba_n = '0; #1;
      chk("R5 live B to A", a_out, 16'h7E02);
      chk("R6 A side enables active low", a_oe, 16'hFFFF);
   endtask

   task automatic t_stored;
      sel_ab = '1; sel_ba = '1; oe_ab = '1; oe_ba_n = '0;
      a_in = 16'h1234; b_in = 16'hABCD;
      pulse('1, '0);
      pulse('0, '1);
      a_in = 16'h5555; b_in = 16'h6666; #1;
      chk("R1 stored A to B", b_out, 16'h1234);
      chk("R2 stored B to A", a_out, 16'hABCD);
      a_in = 16'hC001; b_in = 16'hD00D;
      pulse('1, '1);
      a_in = 16'h0; b_in = 16'h0; #1;
      chk("R10 both clocks together A to B", b_out, 16'hC001);
      chk("R10 both clocks together B to A", a_out, 16'hD00D);
   endtask

   task automatic t_dark_capture;
      sel_ab = '0; sel_ba = '0; oe_ab = '0; oe_ba_n = '1;
      a_in = 16'hBEEF; b_in = 16'hCAFE;
      pulse('1, '1);
      chk("R3 outputs disabled during capture", b_oe | a_oe, 16'h0000);
      a_in = 16'h0; b_in = 16'h0;
      sel_ab = '1; sel_ba = '1; oe_ab = '1; oe_ba_n = '0; #1;
      chk("R3 captured while disabled A to B", b_out, 16'hBEEF);
      chk("R3 captured while disabled B to A", a_out, 16'hCAFE);
   endtask

   task automatic t_lanes;
      sel_ab = '1; sel_ba = '1; oe_ab = '1; oe_ba_n = '0;
      a_in = 16'h4477; b_in = 16'h9911;
      pulse(2'b01, 2'b10);
      #1;
      chk("R7 lane 0 A-to-B only", b_out, 16'hBE77);
      chk("R7 lane 1 B-to-A only", a_out, 16'h99FE);
      sel_ab = 2'b01; oe_ab = 2'b11; a_in = 16'h2200; #1;
      chk("R7 lane 1 live lane 0 stored", b_out, 16'h2277);
      oe_ab = 2'b01; #1;
      chk("R7 lane 1 disabled alone", b_oe, 16'h00FF);
   endtask

   task automatic t_hold;
      @(negedge clk);
      sel_ab = '0; sel_ba = '0; oe_ab = '1; oe_ba_n = '0;
      a_in = 16'h5A5A; b_in = 16'h0; a_ext = '1; b_ext = '0;
      @(posedge clk); #1;
      a_ext = '0; a_in = 16'h1111; b_in = 16'h2222; #1;
      chk("R8 hold B side", b_out, 16'h5A5A);
      chk("R8 hold A side", a_out, 16'h5A5A);
      @(posedge clk); #1;
      chk("R9 hold kept with no driver", b_out, 16'h5A5A);
      b_in = 16'h0F0F; b_ext = 2'b01;
      @(posedge clk); #1;
      b_ext = '0; #1;
      chk("R9 lane 0 from B driver only", a_out, 16'h5A0F);
      a_in = 16'h8800; b_in = 16'h0077; a_ext = '1; b_ext = '1;
      @(posedge clk); #1;
      a_ext = '0; b_ext = '0; #1;
      chk("R9 A driver wins", b_out, 16'h8800);
   endtask

   initial begin
      rst_n = 1'b0; clk_ab = '0; clk_ba = '0; sel_ab = '0; sel_ba = '0;
      oe_ab = '0; oe_ba_n = '1; a_ext = '0; b_ext = '0; a_in = '0; b_in = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_live();
      t_stored();
      t_dark_capture();
      t_lanes();
      t_hold();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule